// File: doc/BRIEF.md
# AXI-Lite Transfer Length Sniffer

This block sits beside an AXI4-Lite write path that leads to a DMA controller. It only listens. It watches the valid signals driven by the manager and the ready and response signals returned by the downstream subordinate, and it drives nothing back onto the bus. From the beats it observes, it rebuilds each complete write. When a write lands on the transfer-length register and its response handshake completes, the block takes the low bits of the written word as the new length.

Software is expected to program a length that already includes eight extra bytes for a 64-bit timestamp. An N-byte payload is therefore written as N+7 instead of N-1. The block reports that value exactly as written and applies no correction.

The committed length crosses into a sample clock domain that runs asynchronously to the bus clock. The crossing uses a toggle request and acknowledge handshake. On the sample side the length appears with a valid pulse that lasts one cycle. If software rewrites the register before the crossing is free, only the newest value is carried over.

Top module: `axil_len_tap`

## Requirements
- R1: While the bus reset is low and after it is released, with no write yet committed, `len_valid` is 0 and `len_out` is 0.
- R2: A write whose 12-bit address equals `LEN_ADDR` (default 0x418, compared on all 12 bits) produces exactly one `len_valid` pulse in the sample domain. The pulse is one sample cycle wide, and `len_out` then carries the written value. In this case the address beat is accepted before the data beat.
- R3: The same result follows when the data beat (wvalid and wready both high) is accepted before the address beat.
- R4: The same result follows when both beats are accepted in the same bus cycle.
- R5: A completed write to any other address produces no `len_valid` pulse and leaves `len_out` unchanged.
- R6: A write is committed only in the cycle where bvalid and bready are both high. While bvalid is held high with bready low, no pulse appears.
- R7: `len_out` equals bits [LEN_W-1:0] of the written data, with no offset added or removed. Higher data bits are dropped.
- R8: Between `len_valid` pulses, `len_out` holds its value.
- R9: When several lengths are committed faster than the crossing completes, `len_out` finally settles on the last one committed.
- R10: A new value is launched into the crossing only after the previous transfer has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | AXI-Lite bus clock |
| bus_rst_n | input | 1 | Active-low reset for the bus domain. The sample-side reset is derived from it |
| mgr_awvalid | input | 1 | Write address valid observed from the manager |
| mgr_awaddr | input | 12 | Write address observed from the manager |
| mgr_wvalid | input | 1 | Write data valid observed from the manager |
| mgr_wdata | input | 32 | Write data observed from the manager |
| mgr_bready | input | 1 | Response ready observed from the manager |
| sub_awready | input | 1 | Address ready observed from the subordinate |
| sub_wready | input | 1 | Data ready observed from the subordinate |
| sub_bvalid | input | 1 | Response valid observed from the subordinate |
| smp_clk | input | 1 | Sample-domain clock, asynchronous to bus_clk |
| len_out | output | LEN_W | Last committed transfer length |
| len_valid | output | 1 | One-cycle pulse when len_out updates |

## Verification
The hardest situation to reach from the ports is a commit that arrives while the crossing is still waiting for the acknowledge of the previous value. Reaching it takes several complete writes issued back to back, each only a few bus cycles long, so that they fit inside one round trip through the sample clock. The bench issues three such writes without pausing and then checks that the final length is the last one written. A second hard case is a response that is held with bready low. The bench keeps bvalid high for many cycles and confirms that no pulse appears before bready rises.

// File: rtl/axil_len_tap_pkg.sv
package axil_len_tap_pkg;

    localparam int AXIL_ADDR_W = 12;
    localparam int AXIL_DATA_W = 32;

    // Returns the inverted level of a single-bit toggle.
    function automatic logic flip(input logic v);
        return ~v;
    endfunction

endpackage

// File: rtl/axil_len_tap_capture.sv
module axil_len_tap_capture
    import axil_len_tap_pkg::*;
#(
    parameter int                     LEN_W    = 24,
    parameter logic [AXIL_ADDR_W-1:0] LEN_ADDR = 12'h418
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   awvalid,
    input  logic [AXIL_ADDR_W-1:0] awaddr,
    input  logic                   wvalid,
    input  logic [AXIL_DATA_W-1:0] wdata,
    input  logic                   bready,
    input  logic                   awready,
    input  logic                   wready,
    input  logic                   bvalid,
    output logic                   commit,
    output logic [LEN_W-1:0]       commit_len
);

    typedef struct packed {
        logic                   aw_got;
        logic [AXIL_ADDR_W-1:0] addr;
        logic                   w_got;
        logic [LEN_W-1:0]       data;
        logic                   commit;
        logic [LEN_W-1:0]       len;
    } cap_t;

    cap_t cap_d, cap_q;

    generate
        if (LEN_W < AXIL_DATA_W) begin : g_drop_hi
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^wdata[AXIL_DATA_W-1:LEN_W];
        end
    endgenerate

    always_comb begin
        logic aw_hs, w_hs, done;
        cap_d        = cap_q;
        cap_d.commit = 1'b0;
        aw_hs = awvalid && awready;
        w_hs  = wvalid && wready;
        done  = bvalid && bready && cap_q.aw_got && cap_q.w_got;
        if (done) begin
            cap_d.aw_got = 1'b0;
            cap_d.w_got  = 1'b0;
            if (cap_q.addr == LEN_ADDR) begin
                cap_d.commit = 1'b1;
                cap_d.len    = cap_q.data;
            end
        end
        if (aw_hs) begin
            cap_d.aw_got = 1'b1;
            cap_d.addr   = awaddr;
        end
        if (w_hs) begin
            cap_d.w_got = 1'b1;
            cap_d.data  = wdata[LEN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign commit     = cap_q.commit;
    assign commit_len = cap_q.len;

endmodule

// File: rtl/axil_len_tap_cdc_src.sv
module axil_len_tap_cdc_src
    import axil_len_tap_pkg::*;
#(
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LEN_W-1:0] push_data,
    input  logic             ack_async,
    output logic             req_tgl,
    output logic [LEN_W-1:0] hold_data,
    output logic             busy
);

    typedef struct packed {
        logic             req;
        logic             ack_s1;
        logic             ack_s2;
        logic [LEN_W-1:0] hold;
        logic             pend;
        logic [LEN_W-1:0] pend_data;
    } src_t;

    src_t src_d, src_q;

    always_comb begin
        logic idle;
        src_d        = src_q;
        src_d.ack_s1 = ack_async;
        src_d.ack_s2 = src_q.ack_s1;
        idle         = (src_q.req == src_q.ack_s2);
        if (push) begin
            if (idle) begin
                src_d.hold = push_data;
                src_d.req  = flip(src_q.req);
                src_d.pend = 1'b0;
            end else begin
                src_d.pend      = 1'b1;
                src_d.pend_data = push_data;
            end
        end else if (idle && src_q.pend) begin
            src_d.hold = src_q.pend_data;
            src_d.req  = flip(src_q.req);
            src_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_d;
    end

    assign req_tgl   = src_q.req;
    assign hold_data = src_q.hold;
    assign busy      = (src_q.req != src_q.ack_s2);

endmodule

// File: rtl/axil_len_tap_cdc_dst.sv
module axil_len_tap_cdc_dst #(
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_async,
    input  logic [LEN_W-1:0] data_async,
    output logic             ack_tgl,
    output logic             valid,
    output logic [LEN_W-1:0] data
);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             s3;
        logic             valid;
        logic [LEN_W-1:0] data;
    } dst_t;

    dst_t dst_d, dst_q;

    always_comb begin
        dst_d       = dst_q;
        dst_d.s1    = req_async;
        dst_d.s2    = dst_q.s1;
        dst_d.s3    = dst_q.s2;
        dst_d.valid = 1'b0;
        if (dst_q.s2 != dst_q.s3) begin
            dst_d.valid = 1'b1;
            dst_d.data  = data_async;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dst_q <= '0;
        else        dst_q <= dst_d;
    end

    assign ack_tgl = dst_q.s3;
    assign valid   = dst_q.valid;
    assign data    = dst_q.data;

endmodule

// File: rtl/axil_len_tap.sv
module axil_len_tap
    import axil_len_tap_pkg::*;
#(
    parameter int                     LEN_W     = 24,
    parameter logic [AXIL_ADDR_W-1:0] LEN_ADDR  = 12'h418,
    parameter int                     RST_SYNC  = 2
) (
    input  logic                   bus_clk,
    input  logic                   bus_rst_n,
    input  logic                   mgr_awvalid,
    input  logic [AXIL_ADDR_W-1:0] mgr_awaddr,
    input  logic                   mgr_wvalid,
    input  logic [AXIL_DATA_W-1:0] mgr_wdata,
    input  logic                   mgr_bready,
    input  logic                   sub_awready,
    input  logic                   sub_wready,
    input  logic                   sub_bvalid,
    input  logic                   smp_clk,
    output logic [LEN_W-1:0]       len_out,
    output logic                   len_valid
);

    logic             cap_commit;
    logic [LEN_W-1:0] cap_len;
    logic             src_req;
    logic [LEN_W-1:0] src_hold;
    logic             src_busy;
    logic             dst_ack;
    logic             smp_rst_n;
    logic [RST_SYNC-1:0] rst_pipe_q;

    // Sample-domain reset: asserted asynchronously, released synchronously.
    always_ff @(posedge smp_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) rst_pipe_q <= '0;
        else            rst_pipe_q <= {rst_pipe_q[RST_SYNC-2:0], 1'b1};
    end
    assign smp_rst_n = rst_pipe_q[RST_SYNC-1];

    axil_len_tap_capture #(.LEN_W(LEN_W), .LEN_ADDR(LEN_ADDR)) cap_i (
        .clk        (bus_clk),
        .rst_n      (bus_rst_n),
        .awvalid    (mgr_awvalid),
        .awaddr     (mgr_awaddr),
        .wvalid     (mgr_wvalid),
        .wdata      (mgr_wdata),
        .bready     (mgr_bready),
        .awready    (sub_awready),
        .wready     (sub_wready),
        .bvalid     (sub_bvalid),
        .commit     (cap_commit),
        .commit_len (cap_len)
    );

    axil_len_tap_cdc_src #(.LEN_W(LEN_W)) src_i (
        .clk       (bus_clk),
        .rst_n     (bus_rst_n),
        .push      (cap_commit),
        .push_data (cap_len),
        .ack_async (dst_ack),
        .req_tgl   (src_req),
        .hold_data (src_hold),
        .busy      (src_busy)
    );

    axil_len_tap_cdc_dst #(.LEN_W(LEN_W)) dst_i (
        .clk        (smp_clk),
        .rst_n      (smp_rst_n),
        .req_async  (src_req),
        .data_async (src_hold),
        .ack_tgl    (dst_ack),
        .valid      (len_valid),
        .data       (len_out)
    );

endmodule

// File: rtl/axil_len_tap_chk.sv
module axil_len_tap_chk #(
    parameter int LEN_W = 24
) (
    input logic             bus_clk,
    input logic             bus_rst_n,
    input logic             smp_clk,
    input logic             smp_rst_n,
    input logic             bvalid,
    input logic             bready,
    input logic             commit,
    input logic             req_tgl,
    input logic             src_busy,
    input logic             len_valid,
    input logic [LEN_W-1:0] len_out
);

    AST_COMMIT_AFTER_B: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        commit |-> $past(bvalid && bready)); // R6

    AST_LAUNCH_WHEN_FREE: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (req_tgl != $past(req_tgl)) |-> !$past(src_busy)); // R10

    AST_VALID_SINGLE: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
        len_valid |=> !len_valid); // R2

    AST_LEN_HELD: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
        !len_valid |-> $stable(len_out)); // R8

endmodule

bind axil_len_tap axil_len_tap_chk #(.LEN_W(LEN_W)) chk_i (
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .smp_clk   (smp_clk),
    .smp_rst_n (smp_rst_n),
    .bvalid    (sub_bvalid),
    .bready    (mgr_bready),
    .commit    (cap_commit),
    .req_tgl   (src_req),
    .src_busy  (src_busy),
    .len_valid (len_valid),
    .len_out   (len_out)
);

// File: tb/axil_len_tap_tb_top.sv
`timescale 1ns/1ps
module axil_len_tap_tb_top;

    localparam int LEN_W = 24;

    logic bus_clk = 1'b0, smp_clk = 1'b0, bus_rst_n = 1'b0;
    logic mgr_awvalid = 0, mgr_wvalid = 0, mgr_bready = 0;
    logic sub_awready = 0, sub_wready = 0, sub_bvalid = 0;
    logic [11:0] mgr_awaddr = '0;
    logic [31:0] mgr_wdata = '0;
    logic [LEN_W-1:0] len_out;
    logic len_valid;

    always #2   bus_clk = ~bus_clk;
    always #3.5 smp_clk = ~smp_clk;

    axil_len_tap #(.LEN_W(LEN_W)) dut_i (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
        .mgr_awvalid(mgr_awvalid), .mgr_awaddr(mgr_awaddr),
        .mgr_wvalid(mgr_wvalid), .mgr_wdata(mgr_wdata), .mgr_bready(mgr_bready),
        .sub_awready(sub_awready), .sub_wready(sub_wready), .sub_bvalid(sub_bvalid),
        .smp_clk(smp_clk), .len_out(len_out), .len_valid(len_valid)
    );

    int checks = 0, failures = 0;
    int pulses = 0, width_err = 0, stable_err = 0;
    logic prev_valid = 0;
    logic [LEN_W-1:0] prev_out = '0;
    bit finished = 0;

    // Sample-side monitor, sampled on the falling edge.
    always @(negedge smp_clk) begin
        if (bus_rst_n) begin
            if (len_valid) pulses++;
            if (len_valid && prev_valid) width_err++;
            if (!len_valid && len_out !== prev_out) stable_err++;
        end
        prev_valid = len_valid;
        prev_out   = len_out;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // order: 0 address first, 1 data first, 2 same cycle
    task automatic do_write(input logic [1:0] order, input logic [11:0] addr,
                            input logic [31:0] data, input int bdly);
        if (order == 2'd2) begin
            mgr_awvalid = 1; sub_awready = 1; mgr_awaddr = addr;
            mgr_wvalid = 1; sub_wready = 1; mgr_wdata = data;
            @(negedge bus_clk);
        end else begin
            for (int k = 0; k < 2; k++) begin
                if ((k == 0) == (order == 2'd0)) begin
                    mgr_awvalid = 1; sub_awready = 1; mgr_awaddr = addr;
                end else begin
                    mgr_wvalid = 1; sub_wready = 1; mgr_wdata = data;
                end
                @(negedge bus_clk);
                mgr_awvalid = 0; sub_awready = 0; mgr_wvalid = 0; sub_wready = 0;
            end
        end
        mgr_awvalid = 0; sub_awready = 0; mgr_wvalid = 0; sub_wready = 0;
        sub_bvalid = 1; mgr_bready = 0;
        repeat (bdly) @(negedge bus_clk);
        mgr_bready = 1;
        @(negedge bus_clk);
        sub_bvalid = 0; mgr_bready = 0;
    endtask

    typedef struct packed {
        logic [1:0]  order;
        logic [11:0] addr;
        logic [31:0] data;
        logic        hit;
        logic [3:0]  bdly;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 12'h418, 32'h0000_1007, 1'b1, 4'd0},  // R2
        '{2'd1, 12'h418, 32'h0000_0207, 1'b1, 4'd1},  // R3
        '{2'd2, 12'h418, 32'hAB12_3457, 1'b1, 4'd0},  // R4 R7
        '{2'd0, 12'h41C, 32'h0000_0055, 1'b0, 4'd0},  // R5
        '{2'd2, 12'h41A, 32'h0000_0033, 1'b0, 4'd2},  // R5
        '{2'd1, 12'h018, 32'h0000_0099, 1'b0, 4'd0},  // R5
        '{2'd0, 12'h418, 32'hFFFF_FFFF, 1'b1, 4'd5},  // R6 R7
        '{2'd2, 12'h000, 32'h0000_0077, 1'b0, 4'd0}   // R5
    };

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [LEN_W-1:0] exp_len;
        int p0;
        repeat (3) @(negedge bus_clk);
        check("R1 valid in reset", {31'd0, len_valid}, 32'd0);
        check("R1 out in reset", {8'd0, len_out}, 32'd0);
        bus_rst_n = 1;
        repeat (10) @(negedge smp_clk);
        check("R1 valid after reset", {31'd0, len_valid}, 32'd0);
        check("R1 out after reset", {8'd0, len_out}, 32'd0);
        @(negedge bus_clk);

        exp_len = '0;
        for (int i = 0; i < 8; i++) begin
            p0 = pulses;
            do_write(VECS[i].order, VECS[i].addr, VECS[i].data, int'(VECS[i].bdly));
            if (VECS[i].hit) exp_len = VECS[i].data[LEN_W-1:0];
            repeat (20) @(negedge smp_clk);
            check($sformatf("R2/R3/R4/R5 pulses vec%0d", i), pulses - p0,
                  VECS[i].hit ? 32'd1 : 32'd0);
            check($sformatf("R7/R5 len vec%0d", i), {8'd0, len_out}, {8'd0, exp_len});
            @(negedge bus_clk);
        end

        // R6: response held without bready: nothing is committed until the handshake
        p0 = pulses;
        mgr_awvalid = 1; sub_awready = 1; mgr_awaddr = 12'h418;
        mgr_wvalid = 1; sub_wready = 1; mgr_wdata = 32'h0000_0A0F;
        @(negedge bus_clk);
        mgr_awvalid = 0; sub_awready = 0; mgr_wvalid = 0; sub_wready = 0;
        sub_bvalid = 1;
        repeat (30) @(negedge bus_clk);
        check("R6 no pulse while bready low", pulses - p0, 32'd0);
        check("R6 length unchanged while bready low", {8'd0, len_out}, {8'd0, exp_len});
        mgr_bready = 1;
        @(negedge bus_clk);
        sub_bvalid = 0; mgr_bready = 0;
        repeat (20) @(negedge smp_clk);
        check("R6 pulse after handshake", pulses - p0, 32'd1);
        check("R6 length after handshake", {8'd0, len_out}, 32'h0000_0A0F);

        // R9 R10: commits faster than the crossing round trip, the last one wins
        @(negedge bus_clk);
        p0 = pulses;
        do_write(2'd2, 12'h418, 32'h0000_1111, 0);
        do_write(2'd2, 12'h418, 32'h0000_2222, 0);
        do_write(2'd2, 12'h418, 32'h0000_3333, 0);
        repeat (40) @(negedge smp_clk);
        check("R9 final length is last written", {8'd0, len_out}, 32'h0000_3333);
        check("R9 R10 at least one and at most three pulses",
              {31'd0, (pulses - p0 >= 1) && (pulses - p0 <= 3)}, 32'd1);

        check("R2 valid pulse one cycle wide", width_err, 32'd0);
        check("R8 length held between pulses", stable_err, 32'd0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule